// File: doc/BRIEF.md
# Stereo Audio Serial Output Formatter

This block turns a stereo pair of 24-bit two's-complement audio samples into a single serial bit stream. An external word clock at the sample rate Fs marks each sample period with its rising edge. The block runs from a fast system clock at 384 times Fs and derives the serial bit timing from it. Each frame carries a left slot followed by a right slot.

The format select input chooses between two slot sizes. The first is 32-bit slots at 64·Fs, with 6 system clocks per bit and 8 trailing zero bits per slot. The second is 24-bit slots at 48·Fs, with 8 system clocks per bit. The right slot always begins half a frame after the frame start, at system-clock cycle 192. The falling time of the word clock plays no part. Both samples and the format are captured together at the frame start. A one-cycle strobe tells the sample source that its words have been taken.

A word-clock rising edge that arrives before a full frame has elapsed restarts the frame. The line is then held at zero until the next on-time edge. If no edge arrives after 384 cycles, the timing freezes on the last bit until the next edge arrives.

Top module: `aud_ser_fmt`

## Requirements
- R1: Out of reset, and until the first word-clock rising edge has been taken in, `sdata` and `smp_take` are 0.
- R2: With `fmt_sel`=0 at frame start, each slot has 32 bits of 6 system clocks each. The 24 data bits go out MSB (bit 23) first, starting at frame cycle 0, and the last 8 bit times of the slot are 0.
- R3: With `fmt_sel`=1 at frame start, each slot has 24 bits of 8 system clocks each, MSB first.
- R4: The right sample's MSB starts at frame cycle 192 (half of 384) for any word-clock high time from 1 clock up to 383 clocks.
- R5: Frame cycle 0 is the third system clock edge counted from the first edge that samples the word clock high, including that edge (two-flop synchronizer plus edge detect). Both samples are captured on that edge, and `smp_take` is 1 for exactly that frame cycle 0. Changes to `left_smp` or `right_smp` after capture do not alter the frame in progress.
- R6: `fmt_sel` is sampled only at frame start, so a change in mid-frame takes effect in the following frame.
- R7: A word-clock rising edge detected before frame cycle 383 restarts the frame at cycle 0, still captures and strobes `smp_take`, and forces `sdata` to 0 for that whole frame.
- R8: If no rising edge arrives by frame cycle 383, the frame timing holds at cycle 383 and `sdata` keeps its last value. A rising edge detected at or after cycle 383 starts a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 384 × sample rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| wclk | input | 1 | Word clock at the sample rate, asynchronous; rising edge starts a frame |
| fmt_sel | input | 1 | Slot format: 0 = 32-bit slots, 1 = 24-bit slots |
| left_smp | input | 24 | Left sample, two's complement |
| right_smp | input | 24 | Right sample, two's complement |
| sdata | output | 1 | Serial data, MSB first |
| smp_take | output | 1 | One-cycle strobe: samples captured, frame cycle 0 |

## Verification
The assertions check on every cycle that the capture strobe lasts a single cycle and that the latched format holds for the whole frame. They also check that the line is zero while idle, in a muted frame and in the padding bits of 32-bit slots, and that a frame with no new edge stays parked on its last cycle. The exact bit sequence needs the bench's reference model. This covers MSB-first order, the bit lengths of 6 and 8 clocks, and the right slot landing at cycle 192 under short and long word-clock pulses. It also covers the immunity to sample and format changes in mid-frame, and the recovery after early and late edges.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;
    typedef enum logic {
        FMT_SLOT32 = 1'b0,
        FMT_SLOT24 = 1'b1
    } slot_fmt_e;
endpackage

// File: rtl/aud_ser_sync.sv
module aud_ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.chain[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/aud_ser_timer.sv
module aud_ser_timer
    import aud_ser_pkg::*;
#(
    parameter int FRAME_CLKS = 384,
    parameter int LONG_SLOT  = 32,
    parameter int SHORT_SLOT = 24,
    localparam int HALF      = FRAME_CLKS / 2,
    localparam int BL_LONG   = HALF / LONG_SLOT,
    localparam int BL_SHORT  = HALF / SHORT_SLOT,
    localparam int BL_MAX    = (BL_LONG > BL_SHORT) ? BL_LONG : BL_SHORT,
    localparam int CNT_W     = $clog2(FRAME_CLKS),
    localparam int PH_W      = (BL_MAX > 1) ? $clog2(BL_MAX) : 1,
    localparam int IDX_W     = $clog2(LONG_SLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_rise,
    input  logic             fmt_in,
    output logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] idx,
    output logic             run,
    output logic             good,
    output logic             mode,
    output logic             take,
    output logic             ld_right,
    output logic             shift_en
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] PRE_HALF_C = CNT_W'(HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PH_W-1:0]  ph;
        logic [IDX_W-1:0] idx;
        logic             run;
        logic             good;
        slot_fmt_e        mode;
        logic             take;
    } tstate_t;

    tstate_t t_q, t_d;
    logic [PH_W-1:0] bl_last;
    logic at_last, advance;

    always_comb begin
        bl_last  = (t_q.mode == FMT_SLOT24) ? PH_W'(BL_SHORT - 1) : PH_W'(BL_LONG - 1);
        at_last  = (t_q.cnt == LAST_C);
        advance  = t_q.run && !at_last && !frame_rise;
        t_d      = t_q;
        t_d.take = 1'b0;
        ld_right = 1'b0;
        shift_en = 1'b0;
        if (frame_rise) begin
            t_d.cnt  = '0;
            t_d.ph   = '0;
            t_d.idx  = '0;
            t_d.run  = 1'b1;
            t_d.good = !t_q.run || at_last;
            t_d.mode = slot_fmt_e'(fmt_in);
            t_d.take = 1'b1;
        end else if (advance) begin
            t_d.cnt = t_q.cnt + 1'b1;
            if (t_q.cnt == PRE_HALF_C) begin
                t_d.ph   = '0;
                t_d.idx  = '0;
                ld_right = 1'b1;
            end else if (t_q.ph == bl_last) begin
                t_d.ph   = '0;
                t_d.idx  = t_q.idx + 1'b1;
                shift_en = 1'b1;
            end else begin
                t_d.ph = t_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cnt  = t_q.cnt;
    assign idx  = t_q.idx;
    assign run  = t_q.run;
    assign good = t_q.good;
    assign mode = t_q.mode;
    assign take = t_q.take;
endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift #(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_frame,
    input  logic [SMP_W-1:0] left_in,
    input  logic [SMP_W-1:0] right_in,
    input  logic             ld_right,
    input  logic             shift_en,
    output logic             msb
);
    typedef struct packed {
        logic [SMP_W-1:0] sh;
        logic [SMP_W-1:0] rhold;
    } shift_t;

    shift_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (load_frame) begin
            s_d.sh    = left_in;
            s_d.rhold = right_in;
        end else if (ld_right) begin
            s_d.sh = s_q.rhold;
        end else if (shift_en) begin
            s_d.sh = {s_q.sh[SMP_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msb = s_q.sh[SMP_W-1];
endmodule

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt #(
    parameter int SMP_W      = 24,
    parameter int FRAME_CLKS = 384,
    parameter int LONG_SLOT  = 32,
    parameter int SHORT_SLOT = 24,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk,
    input  logic             fmt_sel,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    output logic             sdata,
    output logic             smp_take
);
    localparam int CNT_W = $clog2(FRAME_CLKS);
    localparam int IDX_W = $clog2(LONG_SLOT);

    logic             frame_rise;
    logic [CNT_W-1:0] t_cnt;
    logic [IDX_W-1:0] t_idx;
    logic             t_run, t_good, t_mode;
    logic             ld_right, shift_en, sh_msb;

    aud_ser_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(wclk), .rise(frame_rise)
    );

    aud_ser_timer #(
        .FRAME_CLKS(FRAME_CLKS), .LONG_SLOT(LONG_SLOT), .SHORT_SLOT(SHORT_SLOT)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .frame_rise(frame_rise), .fmt_in(fmt_sel),
        .cnt(t_cnt), .idx(t_idx), .run(t_run), .good(t_good), .mode(t_mode),
        .take(smp_take), .ld_right(ld_right), .shift_en(shift_en)
    );

    aud_ser_shift #(.SMP_W(SMP_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .load_frame(frame_rise),
        .left_in(left_smp), .right_in(right_smp),
        .ld_right(ld_right), .shift_en(shift_en), .msb(sh_msb)
    );

    assign sdata = t_run & t_good & (t_idx < IDX_W'(SMP_W)) & sh_msb;
endmodule

// File: rtl/aud_ser_fmt_chk.sv
module aud_ser_fmt_chk #(
    parameter int SMP_W      = 24,
    parameter int FRAME_CLKS = 384,
    parameter int CNT_W      = 9,
    parameter int IDX_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdata,
    input logic             take,
    input logic [CNT_W-1:0] cnt,
    input logic [IDX_W-1:0] idx,
    input logic             run,
    input logic             good,
    input logic             mode
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_CLKS - 1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!sdata && !take));

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !mode && idx >= IDX_W'(SMP_W)) |-> !sdata);

    assert_take_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !take) |-> $stable(mode));

    assert_muted_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !good) |-> !sdata);

    assert_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == LAST_C) |=> (take || cnt == LAST_C));
endmodule

bind aud_ser_fmt aud_ser_fmt_chk #(
    .SMP_W(SMP_W), .FRAME_CLKS(FRAME_CLKS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .take(smp_take),
    .cnt(t_cnt), .idx(t_idx), .run(t_run), .good(t_good), .mode(t_mode)
);

// File: tb/aud_ser_fmt_tb_top.sv
module aud_ser_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic        fmt_sel = 1'b0;
    logic [23:0] left_smp = '0;
    logic [23:0] right_smp = '0;
    logic        sdata, smp_take;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string scen = "reset";

    always #10 clk = ~clk;

    aud_ser_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .fmt_sel(fmt_sel),
        .left_smp(left_smp), .right_smp(right_smp),
        .sdata(sdata), .smp_take(smp_take)
    );

    // behavioural reference
    bit          hist[$];
    bit          m_run, m_good, m_mode, m_take;
    int          m_pos;
    logic [23:0] m_l, m_r;

    function automatic logic exp_bit();
        int ch, p, bl, bi;
        logic [23:0] w;
        if (!m_run || !m_good) return 1'b0;
        ch = (m_pos >= 192) ? 1 : 0;
        p  = m_pos - 192 * ch;
        bl = m_mode ? 8 : 6;
        bi = p / bl;
        w  = ch ? m_r : m_l;
        if (bi >= 24) return 1'b0;
        return w[23 - bi];
    endfunction

    function automatic string req_tag();
        if (!m_run) return "R1";
        if (!m_good) return "R7";
        if (m_pos == 383) return "R8";
        if (m_pos >= 192) return "R4";
        return m_mode ? "R3" : "R2";
    endfunction

    always @(posedge clk) begin
        logic rise, e;
        if (!rst_n) begin
            hist = {1'b0, 1'b0, 1'b0};
            m_run = 0; m_good = 0; m_mode = 0; m_take = 0; m_pos = 0;
            m_l = '0; m_r = '0;
        end else begin
            rise = hist[1] && !hist[2];
            hist.push_front(wclk);
            void'(hist.pop_back());
            m_take = 0;
            if (rise) begin
                m_good = !m_run || (m_pos == 383);
                m_run  = 1;
                m_pos  = 0;
                m_mode = fmt_sel;
                m_l    = left_smp;
                m_r    = right_smp;
                m_take = 1;
            end else if (m_run && m_pos < 383) begin
                m_pos++;
            end
        end
        #5;
        if (!finished) begin
            e = exp_bit();
            checks++;
            if (sdata !== e) begin
                errors++;
                $display("FAIL %s sdata [%s] pos=%0d actual=%b expected=%b",
                         req_tag(), scen, m_pos, sdata, e);
            end
            checks++;
            if (smp_take !== m_take) begin
                errors++;
                $display("FAIL R5 smp_take [%s] pos=%0d actual=%b expected=%b",
                         scen, m_pos, smp_take, m_take);
            end
        end
    end

    task automatic frame(input int len, input int high, input logic f,
                         input logic [23:0] l, input logic [23:0] r, input bit disturb);
        @(negedge clk);
        wclk = 1'b1; fmt_sel = f; left_smp = l; right_smp = r;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (i == high) wclk = 1'b0;
            if (disturb && i == 40) begin
                left_smp = ~l; right_smp = ~r; fmt_sel = ~f;
            end
        end
        if (high >= len) begin
            @(negedge clk);
            wclk = 1'b0;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        scen = "R1 idle after reset";
        repeat (10) @(negedge clk);
        scen = "R2 32-bit slots, 50% word clock";
        frame(384, 192, 1'b0, 24'h800000, 24'h7FFFFF, 0);
        frame(384, 192, 1'b0, 24'hA5C3F1, 24'h0F0F0E, 0);
        frame(384, 192, 1'b0, 24'hFFFFFF, 24'h000001, 0);
        scen = "R4 32-bit slots, short pulse";
        frame(384, 2, 1'b0, 24'h123456, 24'hFEDCBA, 0);
        scen = "R3 24-bit slots, long pulse";
        frame(384, 370, 1'b1, 24'h5A5A5A, 24'hC00003, 0);
        scen = "R4 24-bit slots, short pulse";
        frame(384, 1, 1'b1, 24'h800001, 24'h7FFFFE, 0);
        frame(384, 192, 1'b1, 24'h0000FF, 24'hFF0000, 0);
        scen = "R5 sample change mid-frame";
        frame(384, 192, 1'b0, 24'h3C3C3C, 24'h96A55A, 1);
        scen = "R6 format change mid-frame";
        frame(384, 192, 1'b1, 24'hE1E1E1, 24'h1E1E1E, 1);
        frame(384, 192, 1'b0, 24'h654321, 24'hABCDEF, 0);
        scen = "R7 early word-clock edge";
        frame(150, 60, 1'b1, 24'h111111, 24'h222222, 0);
        frame(384, 192, 1'b1, 24'h333333, 24'h444444, 0);
        scen = "R7 recovery after early edge";
        frame(384, 192, 1'b0, 24'h555555, 24'hAAAAAA, 0);
        scen = "R8 late word-clock edge";
        frame(500, 250, 1'b1, 24'h000003, 24'h800003, 0);
        frame(384, 192, 1'b0, 24'h7654FE, 24'h89AB01, 0);
        scen = "R8 no further edge";
        frame(384, 192, 1'b1, 24'h2468AC, 24'h13579B, 0);
        repeat (100) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule